// File: doc/BRIEF.md
# Period-Register PWM Generator

This block produces a free-running pulse-width modulated output from a clock-enable tick. The tick first passes through a prescaler that divides it by 1, 4 or 16. The prescaled tick then advances an 8-bit cycle counter, which runs from zero up to a programmable terminal value and then starts again. A 10-bit high-time value sets how long the output stays high in each cycle. This value has finer resolution than the counter because the two upper prescaler bits extend the counter into a 10-bit time base.

A separate postscaler counts cycle rollovers. After a programmable number of rollovers it sets a sticky interrupt flag, and software clears that flag with a write-one-to-clear strobe. The prescale selection, terminal value and high time are held in shadow registers. These are reloaded only at a cycle boundary, so a change made in the middle of a cycle never produces a short or split pulse. After the run enable is raised, the waveform repeats without any further action.

Top module: `pwm_period_gen`

## Requirements
- R1: The prescale select `psc_sel` picks the divide ratio: 2'b00 divides the tick by 1, 2'b01 divides it by 4, and 2'b10 or 2'b11 divides it by 16. One output cycle lasts (P+1) × ratio ticks, where P is the terminal value.
- R2: The cycle counter advances once per prescaled tick and counts 0, 1, …, P. On the prescaled tick that follows count P it returns to 0 and a new cycle begins.
- R3: The time base is {cycle count, fine}. Fine is the 2-bit prescaler count for ratio 4, the upper two bits of the 4-bit prescaler count for ratio 16, and 0 for ratio 1. `pwm_out` is high while the time base is below the latched high-time value.
- R4: A high-time value of 0 keeps `pwm_out` low for the whole cycle. A value of 4 × (P+1) or more keeps it high for the whole cycle.
- R5: The high time, terminal value and prescale select are latched when the run starts and at each cycle rollover. A change to these inputs in the middle of a cycle takes effect in the next cycle.
- R6: `run_en` is registered. While the registered run state is low, `pwm_out` is low and all counters are held at zero. The first clock with run active shows time-base state 0.
- R7: All counters advance only on clocks where `tick_en` is high. On every other clock the output state is held.
- R8: With `post_ratio` = N, the interrupt flag is set on the clock after the rollover that completes N+1 rollovers counted since the run started or since the last flag set. N ranges from 0 to 15. The postscaler has no effect on `pwm_out`.
- R9: `irq_flag` stays set until a clock where `irq_clr` is high. If a set and a clear arrive in the same clock, the set takes priority.
- R10: With ratio 16, P = 248 and a high time of 500, each cycle is 3984 ticks long and the output is high for 2000 ticks of it (about 50 %). At a 1 MHz tick this is a period of about 4 ms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Clock enable that advances the counters |
| run_en | input | 1 | Starts the waveform; clears the counters when low |
| psc_sel | input | 2 | Prescale ratio select |
| period_val | input | 8 | Terminal value P of the cycle counter |
| duty_val | input | 10 | High time in time-base units |
| post_ratio | input | 4 | Postscale ratio minus one |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| pwm_out | output | 1 | PWM waveform |
| irq_flag | output | 1 | Sticky postscaled rollover flag |

## Verification
The waveform is compared clock by clock against a time-base model under each prescale ratio. A prescale of 1 shows coarse counter-only steps. A prescale of 4 with a high time of 7 shows the fine bits at work. A prescale of 16 confirms that fine is taken from the upper prescaler bits. High-time values of zero and exactly 4 × (P+1) separate a correct comparison from an off-by-one. A high-time and terminal change made in the middle of a cycle shows whether the shadow registers wait for the rollover. Ticks on alternate clocks show that nothing advances without `tick_en`. The interrupt flag is sampled on the clock before and the clock after the completing rollover, under ratios of 3 and 1, and with a clear held across a set.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  // prescale select encodings
  localparam logic [1:0] PSC_DIV1  = 2'b00;
  localparam logic [1:0] PSC_DIV4  = 2'b01;
  localparam logic [1:0] PSC_DIV16 = 2'b10;

  function automatic logic psc_is_div16(input logic [1:0] sel);
    return sel[1];
  endfunction

  function automatic logic psc_is_div4(input logic [1:0] sel);
    return !sel[1] && sel[0];
  endfunction
endpackage

// File: rtl/pwm_gen_prescaler.sv
module pwm_gen_prescaler
  import pwm_gen_pkg::*;
#(
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [1:0]        sel,
  output logic              last,
  output logic [FINE_W-1:0] fine
);
  localparam int PSC_W = 2 * FINE_W;

  logic [PSC_W-1:0] psc_q, psc_d;
  logic             term;

  always_comb begin
    if (psc_is_div16(sel))     term = &psc_q;
    else if (psc_is_div4(sel)) term = &psc_q[FINE_W-1:0];
    else                       term = 1'b1;
  end

  always_comb begin
    psc_d = psc_q;
    if (clr)       psc_d = '0;
    else if (tick) psc_d = term ? '0 : psc_q + 1'b1;
  end

  always_comb begin
    if (psc_is_div16(sel))     fine = psc_q[PSC_W-1:FINE_W];
    else if (psc_is_div4(sel)) fine = psc_q[FINE_W-1:0];
    else                       fine = '0;
  end

  assign last = tick & term & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end

  // R1: ratio 1 never leaves zero, ratio 4 never touches the upper half
  p_div1_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PSC_DIV1) |-> (psc_q == '0));
  p_div4_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == PSC_DIV4) |-> (psc_q[PSC_W-1:FINE_W] == '0));
endmodule

// File: rtl/pwm_gen_period_ctr.sv
module pwm_gen_period_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap = step & (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= period);
  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_gen_postscaler.sv
module pwm_gen_postscaler #(
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              evt,
  input  logic [POST_W-1:0] ratio,
  output logic              hit
);
  logic [POST_W-1:0] cnt_q, cnt_d;

  assign hit = evt & (cnt_q >= ratio);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (evt) cnt_d = hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_post_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 10,
  parameter int POST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              run_en,
  input  logic [1:0]        psc_sel,
  input  logic [CNT_W-1:0]  period_val,
  input  logic [DUTY_W-1:0] duty_val,
  input  logic [POST_W-1:0] post_ratio,
  input  logic              irq_clr,
  output logic              pwm_out,
  output logic              irq_flag
);
  localparam int FINE_W = DUTY_W - CNT_W;

  logic              run_q;
  logic [CNT_W-1:0]  per_sh_q, per_sh_d;
  logic [DUTY_W-1:0] duty_sh_q, duty_sh_d;
  logic [1:0]        sel_sh_q, sel_sh_d;
  logic              irq_q, irq_d;

  logic              hold_clr, load;
  logic              psc_last, wrap, post_hit;
  logic [FINE_W-1:0] fine;
  logic [CNT_W-1:0]  cnt;
  logic [DUTY_W-1:0] tbase;

  assign hold_clr = ~run_q;
  assign load     = ~run_q | wrap;

  pwm_gen_prescaler #(.FINE_W(FINE_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .tick(tick_en),
    .sel(sel_sh_q), .last(psc_last), .fine(fine)
  );

  pwm_gen_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .step(psc_last),
    .period(per_sh_q), .cnt(cnt), .wrap(wrap)
  );

  pwm_gen_postscaler #(.POST_W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .evt(wrap),
    .ratio(post_ratio), .hit(post_hit)
  );

  always_comb begin
    per_sh_d  = per_sh_q;
    duty_sh_d = duty_sh_q;
    sel_sh_d  = sel_sh_q;
    if (load) begin
      per_sh_d  = period_val;
      duty_sh_d = duty_val;
      sel_sh_d  = psc_sel;
    end
    irq_d = post_hit | (irq_q & ~irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      per_sh_q  <= '0;
      duty_sh_q <= '0;
      sel_sh_q  <= '0;
      irq_q     <= 1'b0;
    end else begin
      run_q     <= run_en;
      per_sh_q  <= per_sh_d;
      duty_sh_q <= duty_sh_d;
      sel_sh_q  <= sel_sh_d;
      irq_q     <= irq_d;
    end
  end

  assign tbase    = {cnt, fine};
  assign pwm_out  = run_q & (tbase < duty_sh_q);
  assign irq_flag = irq_q;

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(duty_sh_q) && $stable(per_sh_q));
  p_start_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (tbase == '0));
  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    post_hit |=> irq_q);
  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
endmodule

// File: tb/pwm_period_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_period_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en, run_en, irq_clr;
  logic [1:0] psc_sel;
  logic [7:0] period_val;
  logic [9:0] duty_val;
  logic [3:0] post_ratio;
  logic       pwm_out, irq_flag;

  int n_chk = 0;
  int n_err = 0;
  int r10_hi = 0;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  pwm_period_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run_en(run_en),
    .psc_sel(psc_sel), .period_val(period_val), .duty_val(duty_val),
    .post_ratio(post_ratio), .irq_clr(irq_clr),
    .pwm_out(pwm_out), .irq_flag(irq_flag)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ratio_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  function automatic logic exp_level(input int sel, input int p, input int d, input int t);
    int div  = ratio_of(sel);
    int c    = t / div;
    int r    = t % div;
    int fine = (div == 4) ? r : (div == 16) ? r / 4 : 0;
    return ((c * 4 + fine) < d);
  endfunction

  task automatic push(input logic lvl, input string tag);
    exp_t it;
    it.lvl = lvl;
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: pops one expected level per clock while the queue is filled
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      if (it.tag == "R10" && pwm_out === 1'b1) r10_hi++;
      check(pwm_out, it.lvl, it.tag);
    end
  end

  // driver: first cycle uses (p1,d1); inputs switch to (p2,d2) mid-cycle
  task automatic run_seq(input int sel, input int p1, input int d1, input int ncyc,
                         input int gap, input int p2, input int d2, input int post,
                         input string tag);
    bit first = 1'b1;
    @(posedge clk); #1;
    psc_sel    = sel[1:0];
    period_val = p1[7:0];
    duty_val   = d1[9:0];
    post_ratio = post[3:0];
    tick_en    = (gap == 1);
    run_en     = 1'b1;
    push(1'b0, tag);  // run state not yet registered
    for (int cyc = 0; cyc < ncyc; cyc++) begin
      int p   = (cyc == 0) ? p1 : p2;
      int d   = (cyc == 0) ? d1 : d2;
      int len = (p + 1) * ratio_of(sel);
      for (int t = 0; t < len; t++) begin
        int reps = first ? 1 : gap;
        first = 1'b0;
        for (int k = 0; k < reps; k++) push(exp_level(sel, p, d, t), tag);
      end
    end
    @(posedge clk); #1;
    period_val = p2[7:0];
    duty_val   = d2[9:0];
    while (q.size() > 0) begin
      if (gap == 2) tick_en = ~tick_en;
      @(posedge clk); #1;
    end
    run_en  = 1'b0;
    tick_en = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(pwm_out, 1'b0, "R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b1; run_en = 1'b0; irq_clr = 1'b0;
    psc_sel = 2'b00; period_val = 8'd9; duty_val = 10'd0; post_ratio = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    check(pwm_out, 1'b0, "R6");
    check(irq_flag, 1'b0, "R9");
    rst_n = 1'b1;

    // R1 R3: ratio 1, coarse steps; postscaler value must not matter (R8)
    run_seq(0, 9, 20, 3, 1, 9, 20, 15, "R3");
    // R1 R3: ratio 4, fine bits give 7 high ticks out of 20
    run_seq(1, 4, 7, 2, 1, 4, 7, 0, "R3");
    // R1 R2: ratio 16, fine from upper prescaler bits; select 2'b11 too
    run_seq(2, 2, 5, 2, 1, 2, 5, 7, "R1");
    run_seq(3, 2, 5, 2, 1, 2, 5, 7, "R2");
    // R4: zero high time, and high time equal to 4*(P+1)
    run_seq(1, 9, 0, 2, 1, 9, 0, 1, "R4");
    run_seq(0, 9, 40, 2, 1, 9, 40, 1, "R4");
    // R5: mid-cycle change applies from the next cycle
    run_seq(0, 9, 8, 3, 1, 5, 30, 3, "R5");
    // R7: tick on alternate clocks
    run_seq(1, 3, 6, 2, 2, 3, 6, 5, "R7");
    // R10: the 4 ms example
    run_seq(2, 248, 500, 2, 1, 248, 500, 0, "R10");
    n_chk++;
    if (r10_hi != 4000) begin
      n_err++;
      $display("FAIL R10: got %0d high ticks expected %0d", r10_hi, 4000);
    end

    // R8 R9: ratio 3 (post_ratio 2), P=4, ratio-1 prescale: rollover k at edge 1+5k
    @(posedge clk); #1;
    psc_sel = 2'b00; period_val = 8'd4; duty_val = 10'd8; post_ratio = 4'd2;
    tick_en = 1'b1; irq_clr = 1'b1; run_en = 1'b1;
    @(posedge clk); #1;
    irq_clr = 1'b0;
    repeat (14) @(posedge clk);
    #1; check(irq_flag, 1'b0, "R8");
    @(posedge clk); #1; check(irq_flag, 1'b1, "R8");
    repeat (2) @(posedge clk);
    #1; check(irq_flag, 1'b1, "R9");
    irq_clr = 1'b1;
    @(posedge clk); #1;
    irq_clr = 1'b0;
    check(irq_flag, 1'b0, "R9");
    repeat (11) @(posedge clk);
    #1; check(irq_flag, 1'b0, "R8");
    @(posedge clk); #1; check(irq_flag, 1'b1, "R8");
    run_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    // R8 R9: ratio 1, clear held high across the set
    post_ratio = 4'd0; irq_clr = 1'b1; run_en = 1'b1;
    @(posedge clk); #1;
    repeat (4) @(posedge clk);
    #1; check(irq_flag, 1'b0, "R8");
    @(posedge clk); #1; check(irq_flag, 1'b1, "R9");
    irq_clr = 1'b0; run_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule